// File: doc/BRIEF.md
# Serial Converter Port and Conversion Sequencer

This block is the digital front end of a serial successive-approximation converter. A host drives a chip-select, a serial clock and a serial data line. The block samples all three with its own system clock and acts on their edges. Each frame shifts a command word in and, at the same time, shifts the most recent result out. A command can start a timed conversion, start a calibration or offset cycle, or change the frame length. While the block is busy its end-of-conversion flag is held low. When the busy interval ends, the flag rises and the value on a parallel sample bus is captured as the new result.

The result is sign-magnitude: one sign bit followed by a 12-bit magnitude, sent most significant bit first. The first result bit is not launched by a serial clock edge. It appears either when chip-select falls, or, when chip-select has stayed low, one clock after the end-of-conversion flag rises. A data-ready flag goes low while result bits are leaving the block and goes high after the last one. A read-only input turns the port into a pure reader that starts nothing. A power-down input holds the block idle, and after release it keeps it busy for a wake-up interval.

Top module: `adcs_port`

## Requirements
- R1: While `cs_n` is low, `sdi` is sampled on each rising `sclk` edge. The first four bits taken after a chip-select fall or after the previous command form the command code, MSB first. The code takes effect after the rising edge whose count equals the current frame length. Codes: 1 = full conversion, 2 = short conversion, 3 = calibration, 4 = offset cycle, 5 = frame length 13, 6 = frame length 9. Any other code does nothing.
- R2: Every result bit after the first changes on a falling `sclk` edge while `cs_n` is low. The order is sign first, then magnitude, MSB first. The result register is zero after reset.
- R3: The first result bit appears on `sdo` at the clock edge that sees `cs_n` fall. If `cs_n` is low when `eoc` rises, the first bit appears one clock after that rise.
- R4: `sdo_oe` is high exactly when `cs_n` was low at the previous clock edge.
- R5: The frame length is 13 after reset. A frame of that many `sclk` pulses carries that many result bits. At length 9, the bits sent are the sign and the top 8 magnitude bits.
- R6: Code 1 or 2 holds `eoc` low for exactly CONV_CYC clocks and then captures `smp_data`. Code 2 clears the four lowest magnitude bits of the captured value.
- R7: Code 3 holds `eoc` low for CAL_CYC clocks and code 4 holds it low for ZERO_CYC clocks. Neither one changes the stored result. The rising edge of `eoc` marks the end of every busy cycle.
- R8: `dor` goes low when a result is loaded. It goes high on the falling `sclk` edge whose count equals the frame length that was current at the load.
- R9: A chip-select fall during a busy cycle, with `read_only` low, ends the cycle: `eoc` is high after that edge and no result is captured.
- R10: With `read_only` high, `sdi` is ignored, no command runs and the stored result is shifted out unchanged. A chip-select fall during a busy cycle is refused: `dor` stays high and the busy cycle runs to its full length.
- R11: `eoc` is low while `pwr_dn` is high. After release, `eoc` stays low until WAKE_CYC clocks past the first edge that sees `pwr_dn` low.
- R12: After reset, `eoc` and `dor` are high and `sdo` and `sdo_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to time busy cycles |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command input |
| read_only | input | 1 | High: port only reads, starts nothing |
| pwr_dn | input | 1 | High: power-down request |
| smp_data | input | RES_W | Parallel sign-magnitude sample bus |
| sdo | output | 1 | Serial result output |
| sdo_oe | output | 1 | Output enable for the tri-state `sdo` pad |
| eoc | output | 1 | Low while a busy cycle runs |
| dor | output | 1 | Low while result bits are being shifted out |

## Verification
The in-RTL assertions check the following on every cycle:
- the output bit count stays inside the frame length latched at load;
- `dor` falls after a load, whichever edge triggered it;
- `eoc` rises only out of a busy cycle, and it drops under power-down;
- an abort idles the sequencer;
- the result changes only at the end of a busy cycle;
- no command is raised from an ignored rising edge.

Other properties need the bench's scenarios, which follow a behavioural model of the port:
- the exact busy lengths per command;
- the recovered serial words at both frame lengths;
- the trimmed short conversion;
- the launch of the first bit after a conversion that finished with chip-select held low;
- the refusal of a read-only access during a busy cycle;
- the retention of the old result after an abort.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    OP_NONE      = 4'h0,
    OP_CONV_FULL = 4'h1,
    OP_CONV_TRIM = 4'h2,
    OP_CAL       = 4'h3,
    OP_ZERO      = 4'h4,
    OP_LEN_LONG  = 4'h5,
    OP_LEN_SHORT = 4'h6
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DOWN} seq_e;
  typedef enum logic [1:0] {LATCH_NONE, LATCH_FULL, LATCH_TRIM} latch_e;
endpackage

// File: rtl/adcs_rx.sv
module adcs_rx
  import adcs_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cs_fall,
  input  logic              sclk_rise,
  input  logic              sdi,
  input  logic [LEN_W-1:0]  len,
  output logic              cmd_vld,
  output logic [CODE_W-1:0] cmd
);
  logic [LEN_W-1:0]  cnt_q;
  logic [CODE_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      sr_q    <= '0;
      cmd_vld <= 1'b0;
      cmd     <= '0;
    end else begin
      cmd_vld <= 1'b0;
      if (cs_fall) begin
        cnt_q <= '0;
      end else if (sclk_rise && en) begin
        if (cnt_q < LEN_W'(CODE_W)) sr_q <= {sr_q[CODE_W-2:0], sdi};
        if (cnt_q == len - 1'b1) begin
          cnt_q   <= '0;
          cmd_vld <= 1'b1;
          cmd     <= sr_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R10
  ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !en) |=> !cmd_vld);
endmodule

// File: rtl/adcs_seq.sv
module adcs_seq
  import adcs_pkg::*;
#(
  parameter int RES_W     = 13,
  parameter int SHORT_W   = 9,
  parameter int LEN_W     = 4,
  parameter int CONV_CYC  = 20,
  parameter int CAL_CYC   = 40,
  parameter int ZERO_CYC  = 12,
  parameter int WAKE_CYC  = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_dn,
  input  logic              abort,
  input  logic              cmd_vld,
  input  logic [CODE_W-1:0] cmd,
  input  logic [RES_W-1:0]  smp,
  output logic [LEN_W-1:0]  len_q,
  output logic [RES_W-1:0]  res_q,
  output logic              eoc_q,
  output logic              done_q
);
  localparam int M1   = (CONV_CYC > CAL_CYC) ? CONV_CYC : CAL_CYC;
  localparam int M2   = (ZERO_CYC > WAKE_CYC) ? ZERO_CYC : WAKE_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  seq_e             st_q, st_n;
  latch_e           kind_q, kind_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [LEN_W-1:0] len_n;
  logic [RES_W-1:0] res_n;
  logic             done_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    kind_n = kind_q;
    len_n  = len_q;
    res_n  = res_q;
    done_n = 1'b0;
    if (pwr_dn) begin
      st_n = ST_DOWN;
    end else begin
      case (st_q)
        ST_DOWN: begin
          st_n   = ST_BUSY;
          cnt_n  = CW'(WAKE_CYC - 1);
          kind_n = LATCH_NONE;
        end
        ST_BUSY: begin
          if (abort) begin
            st_n = ST_IDLE;
          end else if (cnt_q == '0) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
            case (kind_q)
              LATCH_FULL: res_n = smp;
              LATCH_TRIM: res_n = {smp[RES_W-1 -: SHORT_W], {(RES_W-SHORT_W){1'b0}}};
              default:    res_n = res_q;
            endcase
          end else begin
            cnt_n = cnt_q - 1'b1;
          end
        end
        default: begin
          if (cmd_vld) begin
            case (op_e'(cmd))
              OP_CONV_FULL: begin st_n = ST_BUSY; cnt_n = CW'(CONV_CYC - 1); kind_n = LATCH_FULL; end
              OP_CONV_TRIM: begin st_n = ST_BUSY; cnt_n = CW'(CONV_CYC - 1); kind_n = LATCH_TRIM; end
              OP_CAL:       begin st_n = ST_BUSY; cnt_n = CW'(CAL_CYC - 1);  kind_n = LATCH_NONE; end
              OP_ZERO:      begin st_n = ST_BUSY; cnt_n = CW'(ZERO_CYC - 1); kind_n = LATCH_NONE; end
              OP_LEN_LONG:  len_n = LEN_W'(RES_W);
              OP_LEN_SHORT: len_n = LEN_W'(SHORT_W);
              default:      len_n = len_q;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      kind_q <= LATCH_NONE;
      cnt_q  <= '0;
      len_q  <= LEN_W'(RES_W);
      res_q  <= '0;
      eoc_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      kind_q <= kind_n;
      cnt_q  <= cnt_n;
      len_q  <= len_n;
      res_q  <= res_n;
      eoc_q  <= (st_n == ST_IDLE);
      done_q <= done_n;
    end
  end

  // R11
  down_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> !eoc_q);
  // R9
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (abort && st_q == ST_BUSY && !pwr_dn) |=> (eoc_q && !done_q));
  // R7
  end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc_q) |-> $past(st_q == ST_BUSY));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_q) |-> (done_q && $past(st_q == ST_BUSY)));
endmodule

// File: rtl/adcs_tx.sv
module adcs_tx #(
  parameter int RES_W = 13,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             cs_fall,
  input  logic             sclk_fall,
  input  logic             refuse,
  input  logic             done,
  input  logic [LEN_W-1:0] len,
  input  logic [RES_W-1:0] res,
  output logic             sdo_q,
  output logic             sdo_oe_q,
  output logic             dor_q
);
  logic [RES_W-1:0] sr_q;
  logic [LEN_W-1:0] cnt_q, flen_q;
  logic             load;

  assign load = (cs_fall && !refuse) || (done && !cs_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      flen_q   <= LEN_W'(RES_W);
      sdo_q    <= 1'b0;
      sdo_oe_q <= 1'b0;
      dor_q    <= 1'b1;
    end else begin
      sdo_oe_q <= !cs_n;
      if (load) begin
        sdo_q  <= res[RES_W-1];
        sr_q   <= {res[RES_W-2:0], 1'b0};
        cnt_q  <= LEN_W'(1);
        flen_q <= len;
        dor_q  <= 1'b0;
      end else if (sclk_fall && !dor_q) begin
        if (cnt_q == flen_q) begin
          dor_q <= 1'b1;
          sdo_q <= 1'b0;
        end else begin
          sdo_q <= sr_q[RES_W-1];
          sr_q  <= {sr_q[RES_W-2:0], 1'b0};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R8
  count_chk: assert property (@(posedge clk) disable iff (rst)
    !dor_q |-> (cnt_q != '0 && cnt_q <= flen_q));
  // R3
  first_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !cs_n) |=> !dor_q);
  // R4
  select_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_fall && !refuse) |=> (sdo_oe_q && !dor_q));
endmodule

// File: rtl/adcs_port.sv
module adcs_port
  import adcs_pkg::*;
#(
  parameter int RES_W    = 13,
  parameter int SHORT_W  = 9,
  parameter int CONV_CYC = 20,
  parameter int CAL_CYC  = 40,
  parameter int ZERO_CYC = 12,
  parameter int WAKE_CYC = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             read_only,
  input  logic             pwr_dn,
  input  logic [RES_W-1:0] smp_data,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             eoc,
  output logic             dor
);
  localparam int LEN_W = $clog2(RES_W + 1);

  logic              cs_d, sclk_d;
  logic              cs_fall, sclk_rise, sclk_fall;
  logic              cmd_vld, done;
  logic [CODE_W-1:0] cmd;
  logic [LEN_W-1:0]  len;
  logic [RES_W-1:0]  res;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_n;
      sclk_d <= sclk;
    end
  end

  assign cs_fall   = cs_d && !cs_n;
  assign sclk_rise = !sclk_d && sclk && !cs_n;
  assign sclk_fall = sclk_d && !sclk && !cs_n;

  adcs_rx #(.LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst(rst), .en(eoc && !read_only), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sdi(sdi), .len(len), .cmd_vld(cmd_vld), .cmd(cmd)
  );

  adcs_seq #(
    .RES_W(RES_W), .SHORT_W(SHORT_W), .LEN_W(LEN_W), .CONV_CYC(CONV_CYC),
    .CAL_CYC(CAL_CYC), .ZERO_CYC(ZERO_CYC), .WAKE_CYC(WAKE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .abort(cs_fall && !read_only),
    .cmd_vld(cmd_vld), .cmd(cmd), .smp(smp_data), .len_q(len), .res_q(res),
    .eoc_q(eoc), .done_q(done)
  );

  adcs_tx #(.RES_W(RES_W), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cs_fall(cs_fall), .sclk_fall(sclk_fall),
    .refuse(read_only && !eoc), .done(done), .len(len), .res(res),
    .sdo_q(sdo), .sdo_oe_q(sdo_oe), .dor_q(dor)
  );
endmodule

// File: tb/sim_adcs_port.sv
`timescale 1ns/1ps
module sim_adcs_port;
  localparam int CONV = 20, CAL = 40, ZERO = 12, WAKE = 30;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, ro = 1'b0, pwr_dn = 1'b0;
  logic [12:0] smp = 13'h1A5B;
  logic sdo, sdo_oe, eoc, dor;

  always #2.5 clk = ~clk;

  adcs_port #(.RES_W(13), .SHORT_W(9), .CONV_CYC(CONV), .CAL_CYC(CAL),
              .ZERO_CYC(ZERO), .WAKE_CYC(WAKE)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .read_only(ro),
    .pwr_dn(pwr_dn), .smp_data(smp), .sdo(sdo), .sdo_oe(sdo_oe), .eoc(eoc), .dor(dor)
  );

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // behavioural reference model
  bit m_csd, m_sckd, m_oe, m_sdo, m_dor, m_done, m_cmdv, m_eoc;
  int m_st, m_left, m_kind, m_wl, m_in, m_code, m_cmd;
  logic [12:0] m_res;
  bit q[$];
  bit cf, sr, sf, idle0, nd, ncv;
  int wl0;

  always @(posedge clk) begin
    if (rst) begin
      m_csd = 1; m_sckd = 0; m_oe = 0; m_sdo = 0; m_dor = 1; m_done = 0; m_cmdv = 0;
      m_st = 0; m_left = 0; m_kind = 0; m_wl = 13; m_in = 0; m_code = 0; m_cmd = 0;
      m_res = '0; m_eoc = 1; q.delete();
    end else begin
      cf = m_csd && !cs_n;
      sr = !m_sckd && sclk && !cs_n;
      sf = m_sckd && !sclk && !cs_n;
      idle0 = (m_st == 0);
      wl0 = m_wl;
      m_oe = !cs_n;
      // output side
      if ((cf && !(ro && !idle0)) || (m_done && !cs_n)) begin
        q.delete();
        for (int b = 12; b >= 13 - wl0; b--) q.push_back(m_res[b]);
        m_sdo = q.pop_front();
        m_dor = 0;
      end else if (sf && !m_dor) begin
        if (q.size() == 0) begin m_dor = 1; m_sdo = 0; end
        else m_sdo = q.pop_front();
      end
      // sequencer
      nd = 0;
      if (pwr_dn) m_st = 2;
      else if (m_st == 2) begin m_st = 1; m_left = WAKE; m_kind = 0; end
      else if (m_st == 1) begin
        if (cf && !ro) m_st = 0;
        else begin
          m_left--;
          if (m_left == 0) begin
            m_st = 0; nd = 1;
            if (m_kind == 1) m_res = smp;
            else if (m_kind == 2) m_res = smp & 13'h1FF0;
          end
        end
      end else if (m_cmdv) begin
        case (m_cmd)
          1: begin m_st = 1; m_left = CONV; m_kind = 1; end
          2: begin m_st = 1; m_left = CONV; m_kind = 2; end
          3: begin m_st = 1; m_left = CAL;  m_kind = 0; end
          4: begin m_st = 1; m_left = ZERO; m_kind = 0; end
          5: m_wl = 13;
          6: m_wl = 9;
          default: ;
        endcase
      end
      m_done = nd;
      m_eoc = (m_st == 0);
      // command input
      ncv = 0;
      if (cf) m_in = 0;
      else if (sr && idle0 && !ro) begin
        if (m_in < 4) m_code = ((m_code << 1) | int'(sdi)) & 15;
        if (m_in == wl0 - 1) begin m_in = 0; ncv = 1; m_cmd = m_code; end
        else m_in++;
      end
      m_cmdv = ncv;
      m_csd = cs_n;
      m_sckd = sclk;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R2 sdo vs model", 32'(sdo), 32'(m_sdo));
      check("R4 sdo_oe vs model", 32'(sdo_oe), 32'(m_oe));
      check("R7 eoc vs model", 32'(eoc), 32'(m_eoc));
      check("R8 dor vs model", 32'(dor), 32'(m_dor));
    end
  end

  // length of the most recent low stretch of eoc, in clocks
  int run = 0, last_run = 0;
  always @(posedge clk) begin
    if (rst) begin run = 0; last_run = 0; end
    else if (eoc) begin if (run > 0) last_run = run; run = 0; end
    else run++;
  end

  task automatic frame(input int nb, input logic [3:0] code, output logic [12:0] got);
    got = '0;
    for (int i = 0; i < nb; i++) begin
      sdi = (i < 4) ? code[3-i] : 1'b0;
      sclk = 1'b1;
      @(negedge clk);
      got = {got[11:0], sdo};
      sclk = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
    sdi = 1'b0;
  endtask

  task automatic wait_eoc();
    for (int i = 0; i < 500 && !eoc; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic sel(input logic v);
    cs_n = v;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [12:0] got;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check("R12 eoc", 32'(eoc), 1); check("R12 dor", 32'(dor), 1);
    check("R12 sdo_oe", 32'(sdo_oe), 0); check("R12 sdo", 32'(sdo), 0);

    // full conversion, chip-select toggled
    sel(1'b0);
    check("R4 oe on select", 32'(sdo_oe), 1);
    frame(13, 4'h1, got);
    check("R2 reset result zero", 32'(got), 0);
    sel(1'b1);
    check("R4 oe off", 32'(sdo_oe), 0);
    wait_eoc();
    check("R6 conversion length", 32'(last_run), CONV);
    sel(1'b0);
    check("R3 first bit on select fall", 32'(sdo), 32'(smp[12]));
    frame(13, 4'h0, got);
    check("R2 result word", 32'(got), 32'h1A5B);
    check("R8 dor after frame", 32'(dor), 1);
    check("R1 noop keeps idle", 32'(eoc), 1);
    sel(1'b1);

    // short frame length and short conversion
    sel(1'b0); frame(13, 4'h6, got); sel(1'b1);
    smp = 13'h0C3D;
    sel(1'b0); frame(9, 4'h2, got);
    check("R5 nine-bit word", 32'(got[8:0]), 32'(13'h1A5B >> 4));
    sel(1'b1);
    wait_eoc();
    check("R6 short conversion length", 32'(last_run), CONV);
    sel(1'b0); frame(9, 4'h5, got);
    check("R5 nine-bit new word", 32'(got[8:0]), 32'(13'h0C3D >> 4));
    sel(1'b1);
    sel(1'b0); frame(13, 4'h0, got);
    check("R6 trimmed low bits", 32'(got), 32'(13'h0C3D & 13'h1FF0));
    sel(1'b1);

    // continuous select across a conversion
    smp = 13'h15E7;
    sel(1'b0); frame(13, 4'h1, got);
    for (int i = 0; i < 500 && !eoc; i++) @(negedge clk);
    @(negedge clk);
    check("R3 first bit after eoc rise", 32'(sdo), 32'(smp[12]));
    check("R8 dor low on eoc load", 32'(dor), 0);
    @(negedge clk);
    frame(13, 4'h0, got);
    check("R2 continuous word", 32'(got), 32'h15E7);

    // calibration and offset cycles keep the result
    smp = 13'h0777;
    frame(13, 4'h3, got);
    wait_eoc();
    check("R7 calibration length", 32'(last_run), CAL);
    frame(13, 4'h4, got);
    check("R7 result after calibration", 32'(got), 32'h15E7);
    wait_eoc();
    check("R7 offset length", 32'(last_run), ZERO);
    frame(13, 4'h0, got);
    check("R7 result after offset", 32'(got), 32'h15E7);
    sel(1'b1);

    // abort by chip-select fall
    sel(1'b0); frame(13, 4'h1, got);
    cs_n = 1'b1; @(negedge clk);
    cs_n = 1'b0; @(negedge clk);
    check("R9 eoc after abort", 32'(eoc), 1);
    repeat (30) @(negedge clk);
    frame(13, 4'h0, got);
    check("R9 result not captured", 32'(got), 32'h15E7);
    sel(1'b1);

    // read-only access
    ro = 1'b1;
    sel(1'b0); frame(13, 4'h1, got);
    check("R10 read-only word", 32'(got), 32'h15E7);
    repeat (2) @(negedge clk);
    check("R10 no conversion", 32'(eoc), 1);
    sel(1'b1);
    ro = 1'b0;
    sel(1'b0); frame(13, 4'h1, got);
    cs_n = 1'b1; @(negedge clk);
    ro = 1'b1; cs_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 refused dor", 32'(dor), 1);
    check("R10 still busy", 32'(eoc), 0);
    wait_eoc();
    check("R10 busy full length", 32'(last_run), CONV);
    sel(1'b1);
    ro = 1'b0;

    // power-down and wake-up
    pwr_dn = 1'b1;
    repeat (10) @(negedge clk);
    check("R11 eoc low in power-down", 32'(eoc), 0);
    pwr_dn = 1'b0;
    wait_eoc();
    check("R11 wake interval", 32'(last_run), 10 + WAKE);
    sel(1'b0); frame(13, 4'h0, got);
    check("R2 result after wake", 32'(got), 32'h0777);
    sel(1'b1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule